// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets a host processor read and write a bank of internal registers over a four-wire serial link (serial clock, data in, data out, active-low select) acting only as a full-duplex slave. Every transaction opens with sixteen control bits: a direction flag, a 14-bit register address and a burst flag. One data byte follows, or a run of data bytes when the burst flag is set, with the address stepping by one per byte until select is released.

The serial wires are brought into a faster system clock through two-flop synchronisers, and clock edges are found in that domain, so the whole block is one synchronous design. Three static strap inputs pick the clock idle level, the clock phase and the bit order of address and data fields. The block drives a small synchronous register bus (address, write data, write strobe, read strobe) that is visible at its ports and feeds a 16-entry register array held inside the block for testing.

Top module: `spi_regport`

## Requirements
- R1: All four clock modes work: with `strap_cpha`=0 the slave samples data in on the leading clock edge (the edge leaving the idle level `strap_cpol`) and changes data out on the trailing edge; with `strap_cpha`=1 it changes data out on the leading edge and samples on the trailing edge.
- R2: The first bit after select falls is the direction flag (1 = read, 0 = write), the next 14 bits are the register address, and the 16th bit is the burst flag; data bytes follow.
- R3: With `strap_lsb_first`=0 the address and data fields travel most significant bit first; with 1 they travel least significant bit first. The direction flag stays first and the burst flag stays sixteenth in both settings.
- R4: A write presents the address and the received byte on the bus with a one-cycle `bus_wr` after the eighth data bit, and the addressed register takes the byte.
- R5: A read pulses `bus_rd` after the sixteenth control bit and shifts the register contents out on `spi_miso` starting with the first data bit, in the selected bit order.
- R6: With the burst flag set, each further data byte uses the address one higher than the previous byte, for reads and writes, until select rises; with it clear, bytes after the first cause no write.
- R7: Releasing select before the eighth bit of a data byte causes no write; the next select assertion restarts the frame at the direction flag.
- R8: `spi_miso` is low whenever `spi_cs_n` is high.
- R9: The array holds 16 bytes at addresses 0 to 15, all zero after reset; writes to higher addresses change nothing and reads from them return zero.
- R10: `bus_wr` and `bus_rd` are single-cycle strobes and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low select |
| strap_cpol | input | 1 | Serial clock idle level |
| strap_cpha | input | 1 | Serial clock phase |
| strap_lsb_first | input | 1 | 1: address and data fields least significant bit first |
| spi_miso | output | 1 | Serial data to the host, low while deselected |
| bus_addr | output | 14 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |

## Verification
The assertions rely on the host keeping the serial clock at its idle level whenever select changes, leaving at least two system cycles between successive serial clock edges, and holding the straps still while select is low. The bench master holds each serial clock level for eight system cycles, moves select only with the clock idle, and changes strap settings only between frames with a settling gap, so the strobe and frame-restart properties are exercised only within those limits.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CTRL,
    ST_DATA,
    ST_DONE
  } frame_st_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              csn_s,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              miso
);
  localparam int CTRL_BITS = ADDR_W + 2;
  localparam int CW = $clog2(CTRL_BITS);
  localparam int BW = $clog2(DATA_W);

  frame_st_e         st, st_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic [BW-1:0]     bcnt, bcnt_n;
  logic              rw, rw_n, burst, burst_n;
  logic [ADDR_W-1:0] adr_sr, adr_sr_n, cur, cur_n, baddr_n;
  logic [DATA_W-1:0] rx_n, rx, tx, tx_n, wd_n;
  logic              wr_n, rd_n, miso_n;
  logic              sclk_q, csn_q;
  logic              rise, fall, lead, trail, smp, shf, start;

  assign rise  = sclk_s & ~sclk_q;
  assign fall  = ~sclk_s & sclk_q;
  assign lead  = cpol ? fall : rise;
  assign trail = cpol ? rise : fall;
  assign smp   = cpha ? trail : lead;
  assign shf   = cpha ? lead : trail;
  assign start = csn_q & ~csn_s;

  always_comb begin
    st_n = st; cnt_n = cnt; bcnt_n = bcnt; rw_n = rw; burst_n = burst;
    adr_sr_n = adr_sr; cur_n = cur; baddr_n = bus_addr; rx_n = rx;
    wd_n = bus_wdata; wr_n = 1'b0; rd_n = 1'b0; tx_n = tx; miso_n = miso;
    if (bus_rd) tx_n = rdata;
    if (csn_s) begin
      st_n = ST_IDLE;
      miso_n = 1'b0;
    end else if (start) begin
      st_n = ST_CTRL; cnt_n = '0; bcnt_n = '0; miso_n = 1'b0;
    end else begin
      if (shf && st == ST_DATA && rw) begin
        miso_n = lsb_first ? tx[0] : tx[DATA_W-1];
        tx_n   = lsb_first ? (tx >> 1) : (tx << 1);
      end
      if (smp) begin
        unique case (st)
          ST_CTRL: begin
            cnt_n = cnt + CW'(1);
            if (cnt == '0) begin
              rw_n = mosi_s;
            end else if (cnt <= CW'(ADDR_W)) begin
              adr_sr_n = lsb_first ? {mosi_s, adr_sr[ADDR_W-1:1]}
                                   : {adr_sr[ADDR_W-2:0], mosi_s};
            end else begin
              burst_n = mosi_s;
              st_n    = ST_DATA;
              cur_n   = adr_sr;
              baddr_n = adr_sr;
              rd_n    = rw;
            end
          end
          ST_DATA: begin
            rx_n   = lsb_first ? {mosi_s, rx[DATA_W-1:1]} : {rx[DATA_W-2:0], mosi_s};
            bcnt_n = bcnt + BW'(1);
            if (bcnt == BW'(DATA_W - 1)) begin
              bcnt_n = '0;
              if (!rw) begin
                wd_n = rx_n; wr_n = 1'b1; baddr_n = cur;
              end
              if (burst) begin
                cur_n = cur + ADDR_W'(1);
                if (rw) begin
                  baddr_n = cur + ADDR_W'(1);
                  rd_n    = 1'b1;
                end
              end else begin
                st_n = ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; bcnt <= '0; rw <= 1'b0; burst <= 1'b0;
      adr_sr <= '0; cur <= '0; bus_addr <= '0; rx <= '0; bus_wdata <= '0;
      bus_wr <= 1'b0; bus_rd <= 1'b0; tx <= '0; miso <= 1'b0;
      sclk_q <= 1'b0; csn_q <= 1'b1;
    end else begin
      st <= st_n; cnt <= cnt_n; bcnt <= bcnt_n; rw <= rw_n; burst <= burst_n;
      adr_sr <= adr_sr_n; cur <= cur_n; bus_addr <= baddr_n; rx <= rx_n;
      bus_wdata <= wd_n; bus_wr <= wr_n; bus_rd <= rd_n; tx <= tx_n;
      miso <= miso_n; sclk_q <= sclk_s; csn_q <= csn_s;
    end
  end

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == ST_CTRL && cnt == '0 && bcnt == '0));
  p_wr_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(!csn_s));
  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  p_fetch_on_ctrl_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_CTRL && st == ST_DATA) |-> (bus_rd == rw));
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int NREGS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IW = $clog2(NREGS);

  logic [NREGS-1:0][DATA_W-1:0] mem;
  logic [NREGS-1:0]             we;
  logic                         in_range;

  assign in_range = (addr < ADDR_W'(NREGS));

  for (genvar g = 0; g < NREGS; g++) begin : g_we
    assign we[g] = wr && in_range && (addr[IW-1:0] == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (we[i]) mem[i] <= wdata;
      end
    end
  end

  assign rdata = in_range ? mem[addr[IW-1:0]] : '0;

  p_oob_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !in_range) |=> $stable(mem));
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  input  logic              strap_cpol,
  input  logic              strap_cpha,
  input  logic              strap_lsb_first,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd
);
  logic [1:0]        rst_q;
  logic              rst_sn;
  logic [2:0]        pins_s;
  logic              miso_q;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  spi_regport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .din({spi_cs_n, spi_mosi, spi_sclk}),
    .dout(pins_s)
  );

  spi_regport_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_sn),
    .cpol(strap_cpol), .cpha(strap_cpha), .lsb_first(strap_lsb_first),
    .sclk_s(pins_s[0]), .mosi_s(pins_s[1]), .csn_s(pins_s[2]),
    .rdata(rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .miso(miso_q)
  );

  spi_regport_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk(clk), .rst_n(rst_sn),
    .addr(bus_addr), .wdata(bus_wdata), .wr(bus_wr), .rdata(rdata)
  );

  assign spi_miso = miso_q & ~spi_cs_n;
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  logic clk = 1'b0;
  logic rst_n, sclk, mosi, csn, cpol, cpha, lsbf;
  logic miso, bus_wr, bus_rd;
  logic [13:0] bus_addr;
  logic [7:0]  bus_wdata;

  int n_chk = 0, n_fail = 0, wr_cnt = 0, dbl = 0;
  logic [13:0] cap_a;
  logic [7:0]  cap_d;
  logic wr_prev = 1'b0, rd_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(csn),
    .strap_cpol(cpol), .strap_cpha(cpha), .strap_lsb_first(lsbf),
    .spi_miso(miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd)
  );

  always @(posedge clk) begin
    if (bus_wr) begin wr_cnt++; cap_a = bus_addr; cap_d = bus_wdata; end
    if ((bus_wr && wr_prev) || (bus_rd && rd_prev) || (bus_wr && bus_rd)) dbl++;
    wr_prev = bus_wr; rd_prev = bus_rd;
  end

  // {cpol, cpha, lsb_first, addr, data}
  localparam logic [24:0] VEC [8] = '{
    {3'b000, 14'd3,  8'hA5}, {3'b001, 14'd12, 8'h3C},
    {3'b010, 14'd1,  8'h81}, {3'b011, 14'd14, 8'h7E},
    {3'b100, 14'd10, 8'h0F}, {3'b101, 14'd7,  8'hC2},
    {3'b110, 14'd15, 8'h5A}, {3'b111, 14'd2,  8'hE1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic xbit(input logic mo, output logic mi);
    if (!cpha) begin
      mosi = mo; half(); sclk = ~cpol; mi = miso; half(); sclk = cpol;
    end else begin
      sclk = ~cpol; mosi = mo; half(); sclk = cpol; mi = miso; half();
    end
  endtask

  task automatic set_mode(input logic p, input logic h, input logic s);
    cpol = p; cpha = h; lsbf = s; sclk = p;
    repeat (20) @(negedge clk);
  endtask

  task automatic frame(input logic rw, input logic [13:0] a, input logic bst,
                       input int nbytes, input logic [31:0] wd, input int tail,
                       output logic [31:0] rd);
    logic m;
    rd = '0;
    sclk = cpol; csn = 1'b0; half();
    xbit(rw, m);
    for (int i = 0; i < 14; i++) xbit(lsbf ? a[i] : a[13-i], m);
    xbit(bst, m);
    for (int k = 0; k < nbytes; k++)
      for (int i = 0; i < 8; i++) begin
        xbit(wd[8*k + (lsbf ? i : 7-i)], m);
        rd[8*k + (lsbf ? i : 7-i)] = m;
      end
    for (int i = 0; i < tail; i++) xbit(1'b1, m);
    half(); csn = 1'b1; half(); half();
  endtask

  task automatic rd1(input logic [13:0] a, output logic [7:0] v);
    logic [31:0] r;
    frame(1'b1, a, 1'b0, 1, 32'h0, 0, r);
    v = r[7:0];
  endtask

  task automatic wr1(input logic [13:0] a, input logic [7:0] v);
    logic [31:0] r;
    frame(1'b0, a, 1'b0, 1, {24'h0, v}, 0, r);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  v;
    int w0;
    rst_n = 1'b0; csn = 1'b1; sclk = 1'b0; mosi = 1'b0;
    cpol = 1'b0; cpha = 1'b0; lsbf = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 reset miso", miso, 0);
    chk("R10 reset wr", bus_wr, 0);
    chk("R10 reset rd", bus_rd, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    rd1(14'd0, v); chk("R9 reset value", v, 0);

    // R1 R2 R3 R4 R5: table of modes, bit orders, addresses and data
    for (int n = 0; n < 8; n++) begin
      set_mode(VEC[n][24], VEC[n][23], VEC[n][22]);
      w0 = wr_cnt;
      wr1(VEC[n][21:8], VEC[n][7:0]);
      chk("R4 one write strobe", wr_cnt, w0 + 1);
      chk("R2 decoded address", cap_a, VEC[n][21:8]);
      chk("R4 write data", cap_d, VEC[n][7:0]);
      rd1(VEC[n][21:8], v);
      chk("R1 R5 read back on miso", v, VEC[n][7:0]);
    end

    // R3: write LSB-first, read MSB-first
    set_mode(1'b0, 1'b0, 1'b1);
    wr1(14'd5, 8'h1E);
    set_mode(1'b0, 1'b0, 1'b0);
    rd1(14'd5, v); chk("R3 cross bit order", v, 8'h1E);

    // R6: burst write then burst read
    set_mode(1'b0, 1'b1, 1'b0);
    w0 = wr_cnt;
    frame(1'b0, 14'd6, 1'b1, 3, 32'h00332211, 0, r);
    chk("R6 burst write strobes", wr_cnt, w0 + 3);
    rd1(14'd6, v); chk("R6 burst byte0", v, 8'h11);
    rd1(14'd7, v); chk("R6 burst byte1", v, 8'h22);
    rd1(14'd8, v); chk("R6 burst byte2", v, 8'h33);
    set_mode(1'b1, 1'b0, 1'b1);
    frame(1'b1, 14'd6, 1'b1, 3, 32'h0, 0, r);
    chk("R6 burst read", r[23:0], 24'h332211);

    // R6: no burst, extra byte ignored
    set_mode(1'b0, 1'b0, 1'b0);
    w0 = wr_cnt;
    frame(1'b0, 14'd9, 1'b0, 2, 32'h00009944, 0, r);
    chk("R6 single write strobe", wr_cnt, w0 + 1);
    rd1(14'd9, v);  chk("R6 first byte written", v, 8'h44);
    rd1(14'd10, v); chk("R6 next address untouched", v, 8'h0F);

    // R7: abort mid byte
    w0 = wr_cnt;
    frame(1'b0, 14'd9, 1'b0, 0, 32'h0, 5, r);
    chk("R7 no strobe on abort", wr_cnt, w0);
    rd1(14'd9, v); chk("R7 register kept after abort", v, 8'h44);

    // R9: out of range
    wr1(14'd20, 8'h55);
    rd1(14'd20, v); chk("R9 out of range reads zero", v, 0);
    rd1(14'd4, v);  chk("R9 no aliasing", v, 0);

    // R8: miso low after reading all ones
    wr1(14'd0, 8'hFF);
    rd1(14'd0, v); chk("R5 all ones", v, 8'hFF);
    chk("R8 miso idle low", miso, 0);

    chk("R10 strobe shape", dbl, 0);
    summary();
  end
endmodule